// File: doc/BRIEF.md
# Address window decoder

This block decides which target port a transaction goes to. It compares the upper bits of each 48-bit transaction address against a bank of address windows that software programs. Each window has an enable bit, a 4-bit target number, an inclusive range in 1 MB blocks, and a set of four secure-only attribute bits. When a window matches, the decoder reports a hit, the target, the index of the winning window and whether the access breaks that window's security attributes.

Window 0 is reserved for configuration space. It always spans sixteen 1 MB blocks from its low address, and its stored high address has no effect. Its enable bit cannot be cleared, but software may move it by rewriting its low address. The window registers are reached through a plain 32-bit read/write port. Writes and reads made by non-secure software to a control register are filtered by that window's attribute bits.

Top module: `addr_window_decoder`

## Requirements
- R1: There are 16 windows with a 0x20-byte register stride (window index in reg_addr[8:5]). Within a window, byte offset 0x0 is control, 0x4 is security, 0x8 is low address and 0xC is high address. Read data is on reg_rdata one cycle after reg_rd.
- R2: Control bit 0 is the enable and control bits [11:8] are the target number. A window whose enable is 0 never hits.
- R3: The low and high registers store transaction address bits [47:20] in register bits [31:4]. Register bits [3:0] always read as zero.
- R4: A window with index 1 to 15 hits when it is enabled and low <= addr[47:20] <= high. Both ends of the range are included.
- R5: Window 0 hits when low <= addr[47:20] < low + 16. Its high register is ignored, and rewriting its low register moves the window.
- R6: The enable of window 0 cannot be cleared. Its control bit 0 always reads 1.
- R7: When several windows hit, the lowest-numbered one supplies the target and the index.
- R8: When no window hits, dec_hit, dec_tgt, dec_idx and dec_viol are all zero.
- R9: Security register bit 3 marks a window as secure-only for reads, and bit 2 marks it secure-only for writes. A non-secure access of the marked kind to the winning window sets dec_viol. A secure access never does.
- R10: When security bit 0 of a window is set, a non-secure write to its control register is dropped. A secure write is still applied.
- R11: When security bit 1 of a window is set, a non-secure read of its control register returns zero. A secure read returns the stored value.
- R12: The decode outputs are registered and reflect the address presented one cycle earlier. A register write affects the decode made in the next cycle.
- R13: After reset, windows 1 to 15 have every field zero. Window 0 is enabled, with low address 0 and target 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_secure | input | 1 | Register access is secure |
| reg_addr | input | 9 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| dec_addr | input | 48 | Transaction address |
| dec_write | input | 1 | Transaction is a write (0 means read) |
| dec_secure | input | 1 | Transaction is secure |
| dec_hit | output | 1 | Some window matched |
| dec_tgt | output | 4 | Target of the winning window |
| dec_idx | output | 4 | Index of the winning window |
| dec_viol | output | 1 | Security attribute violation |

## Verification
The decode results for an address are due one clock edge after that address is presented. Register read data is due one edge after the read strobe. A write counts as done at the edge that captures it, so a decode presented straight after the write must already see the new value. The bench drives every input on the falling edge and samples at the following falling edge, so each check lands on the cycle its result is due. Priority, the inclusive range ends, window 0's fixed span and its relocation, and each security bit are each checked with an address chosen to sit exactly on the boundary in question.

// File: rtl/awd_pkg.sv
package awd_pkg;
    localparam int ADDR_W   = 48;
    localparam int GRAN_LG  = 20;
    localparam int BLK_W    = ADDR_W - GRAN_LG;
    localparam int TGT_W    = 4;
    localparam int SEC_W    = 4;
    localparam int CFG_BLKS = 16;
    localparam int NUM_WIN_DEF = 16;
    localparam int DATA_W   = 32;
    localparam int BLK_LSB  = DATA_W - BLK_W;

    // register word selectors inside one window
    localparam logic [2:0] SEL_CTRL = 3'd0;
    localparam logic [2:0] SEL_SEC  = 3'd1;
    localparam logic [2:0] SEL_LO   = 3'd2;
    localparam logic [2:0] SEL_HI   = 3'd3;

    // bit positions
    localparam int CTRL_EN  = 0;
    localparam int CTRL_TGT = 8;
    localparam int SEC_CW   = 0;
    localparam int SEC_CR   = 1;
    localparam int SEC_DW   = 2;
    localparam int SEC_DR   = 3;

    typedef struct packed {
        logic             en;
        logic [TGT_W-1:0] tgt;
        logic [SEC_W-1:0] sec;
        logic [BLK_W-1:0] lo;
        logic [BLK_W-1:0] hi;
    } win_t;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
    import awd_pkg::*;
#(
    parameter int NUM_WIN = NUM_WIN_DEF,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int REG_AW = IDX_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_secure,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output win_t              win_o [NUM_WIN]
);
    typedef struct packed {
        win_t [NUM_WIN-1:0] win;
        logic [DATA_W-1:0]  rdata;
    } rf_state_t;

    rf_state_t s_d, s_q;

    logic [IDX_W-1:0] widx;
    logic [2:0]       rsel;
    logic             widx_ok;
    logic [DATA_W-1:0] rd_val;
    win_t             cur;

    assign widx    = reg_addr[REG_AW-1:5];
    assign rsel    = reg_addr[4:2];
    assign widx_ok = (32'(widx) < NUM_WIN);

    logic unused_addr;
    assign unused_addr = ^reg_addr[1:0];

    always_comb begin
        s_d = s_q;
        cur = widx_ok ? s_q.win[widx] : '0;

        rd_val = '0;
        case (rsel)
            SEL_CTRL: begin
                if (reg_secure || !cur.sec[SEC_CR]) begin
                    rd_val[CTRL_EN]             = cur.en;
                    rd_val[CTRL_TGT +: TGT_W]   = cur.tgt;
                end
            end
            SEL_SEC: rd_val[SEC_W-1:0]         = cur.sec;
            SEL_LO:  rd_val[DATA_W-1:BLK_LSB]  = cur.lo;
            SEL_HI:  rd_val[DATA_W-1:BLK_LSB]  = cur.hi;
            default: rd_val = '0;
        endcase

        if (reg_rd) begin
            s_d.rdata = rd_val;
        end

        if (reg_wr && widx_ok) begin
            case (rsel)
                SEL_CTRL: begin
                    if (reg_secure || !cur.sec[SEC_CW]) begin
                        s_d.win[widx].en  = reg_wdata[CTRL_EN];
                        s_d.win[widx].tgt = reg_wdata[CTRL_TGT +: TGT_W];
                    end
                end
                SEL_SEC: s_d.win[widx].sec = reg_wdata[SEC_W-1:0];
                SEL_LO:  s_d.win[widx].lo  = reg_wdata[DATA_W-1:BLK_LSB];
                SEL_HI:  s_d.win[widx].hi  = reg_wdata[DATA_W-1:BLK_LSB];
                default: ;
            endcase
        end

        // configuration window stays active
        s_d.win[0].en = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q           <= '0;
            s_q.win[0].en <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign reg_rdata = s_q.rdata;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_out
        assign win_o[g] = s_q.win[g];
    end

    // R10
    ctrl_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && widx_ok && rsel == SEL_CTRL && !reg_secure && s_q.win[widx].sec[SEC_CW])
        |=> (s_q.win[$past(widx)].tgt == $past(s_q.win[widx].tgt)
             && s_q.win[$past(widx)].en == $past(s_q.win[widx].en)));

    // R3
    lo_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && widx_ok && rsel == SEL_LO)
        |=> s_q.win[$past(widx)].lo == $past(reg_wdata[DATA_W-1:BLK_LSB]));

    // R3
    rd_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_rd) && ($past(rsel) == SEL_LO || $past(rsel) == SEL_HI)
        |-> reg_rdata[BLK_LSB-1:0] == '0);
endmodule

// File: rtl/awd_match.sv
module awd_match
    import awd_pkg::*;
#(
    parameter int NUM_WIN = NUM_WIN_DEF
) (
    input  win_t             win_i [NUM_WIN],
    input  logic [BLK_W-1:0] blk,
    output logic [NUM_WIN-1:0] match
);
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        if (g == 0) begin : g_cfg
            logic [BLK_W:0] end_x;
            assign end_x    = {1'b0, win_i[g].lo} + (BLK_W+1)'(CFG_BLKS);
            assign match[g] = win_i[g].en
                              && (blk >= win_i[g].lo)
                              && ({1'b0, blk} < end_x);
        end else begin : g_rng
            assign match[g] = win_i[g].en
                              && (blk >= win_i[g].lo)
                              && (blk <= win_i[g].hi);
        end
    end
endmodule

// File: rtl/awd_select.sv
module awd_select
    import awd_pkg::*;
#(
    parameter int NUM_WIN = NUM_WIN_DEF,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_WIN-1:0] match,
    input  win_t               win_i [NUM_WIN],
    input  logic               dec_write,
    input  logic               dec_secure,
    output logic               hit_o,
    output logic [TGT_W-1:0]   tgt_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               viol_o
);
    typedef struct packed {
        logic             hit;
        logic [TGT_W-1:0] tgt;
        logic [IDX_W-1:0] idx;
        logic             viol;
    } sel_state_t;

    sel_state_t s_d, s_q;
    logic [IDX_W-1:0] pick;
    win_t             w;

    localparam logic [NUM_WIN-1:0] ONE = NUM_WIN'(1);

    always_comb begin
        pick = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (match[i]) pick = IDX_W'(i);
        end
        w = win_i[pick];

        s_d = '0;
        if (|match) begin
            s_d.hit  = 1'b1;
            s_d.tgt  = w.tgt;
            s_d.idx  = pick;
            s_d.viol = !dec_secure && (dec_write ? w.sec[SEC_DW] : w.sec[SEC_DR]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit_o  = s_q.hit;
    assign tgt_o  = s_q.tgt;
    assign idx_o  = s_q.idx;
    assign viol_o = s_q.viol;

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.hit |-> (s_q.tgt == '0 && s_q.idx == '0 && !s_q.viol));

    // R9
    viol_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.viol |-> s_q.hit);

    // R7
    lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|match) |=> (s_q.hit
            && (($past(match) & ((ONE << s_q.idx) - ONE)) == '0)
            && ((($past(match) >> s_q.idx) & ONE) == ONE)));

    // R9
    secure_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_secure |=> !s_q.viol);
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
    import awd_pkg::*;
#(
    parameter int NUM_WIN = NUM_WIN_DEF,
    localparam int IDX_W  = $clog2(NUM_WIN),
    localparam int REG_AW = IDX_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_secure,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ADDR_W-1:0] dec_addr,
    input  logic              dec_write,
    input  logic              dec_secure,
    output logic              dec_hit,
    output logic [TGT_W-1:0]  dec_tgt,
    output logic [IDX_W-1:0]  dec_idx,
    output logic              dec_viol
);
    win_t               wins [NUM_WIN];
    logic [NUM_WIN-1:0] match;
    logic [BLK_W-1:0]   blk;

    assign blk = dec_addr[ADDR_W-1:GRAN_LG];

    logic unused_offset;
    assign unused_offset = ^dec_addr[GRAN_LG-1:0];

    awd_regfile #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_secure (reg_secure),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .win_o      (wins)
    );

    awd_match #(.NUM_WIN(NUM_WIN)) u_match (
        .win_i (wins),
        .blk   (blk),
        .match (match)
    );

    awd_select #(.NUM_WIN(NUM_WIN)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .match      (match),
        .win_i      (wins),
        .dec_write  (dec_write),
        .dec_secure (dec_secure),
        .hit_o      (dec_hit),
        .tgt_o      (dec_tgt),
        .idx_o      (dec_idx),
        .viol_o     (dec_viol)
    );

    // R6
    cfg_always_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk >= wins[0].lo && {1'b0, blk} < ({1'b0, wins[0].lo} + (BLK_W+1)'(CFG_BLKS)))
        |=> dec_hit);
endmodule

// File: tb/addr_window_decoder_bench.sv
module addr_window_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_secure = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [47:0] dec_addr = '0;
    logic        dec_write = 1'b0, dec_secure = 1'b0;
    logic        dec_hit, dec_viol;
    logic [3:0]  dec_tgt, dec_idx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    addr_window_decoder u_addr_window_decoder (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_secure(reg_secure),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dec_addr(dec_addr), .dec_write(dec_write), .dec_secure(dec_secure),
        .dec_hit(dec_hit), .dec_tgt(dec_tgt), .dec_idx(dec_idx), .dec_viol(dec_viol)
    );

    typedef struct packed {
        logic [47:0] addr;
        logic        wr;
        logic        sec;
        logic        hit;
        logic [3:0]  tgt;
        logic [3:0]  idx;
        logic        viol;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{48'h0000_0000_0000, 1'b0, 1'b0, 1'b1, 4'h0, 4'd0,  1'b0}, // R5 cfg start
        '{48'h0000_00FF_FFFF, 1'b0, 1'b0, 1'b1, 4'h0, 4'd0,  1'b0}, // R5 cfg last byte
        '{48'h0000_0100_0000, 1'b0, 1'b0, 1'b1, 4'h3, 4'd1,  1'b0}, // R4 low end
        '{48'h0000_017F_FFFF, 1'b0, 1'b0, 1'b1, 4'h3, 4'd1,  1'b0}, // R4
        '{48'h0000_0180_0000, 1'b0, 1'b0, 1'b1, 4'h3, 4'd1,  1'b0}, // R7 overlap
        '{48'h0000_0200_0000, 1'b0, 1'b0, 1'b1, 4'h5, 4'd2,  1'b0}, // R9 read ok
        '{48'h0000_0200_0000, 1'b1, 1'b0, 1'b1, 4'h5, 4'd2,  1'b1}, // R9 ns write
        '{48'h0000_0200_0000, 1'b1, 1'b1, 1'b1, 4'h5, 4'd2,  1'b0}, // R9 secure write
        '{48'h0000_02FF_FFFF, 1'b1, 1'b0, 1'b1, 4'h5, 4'd2,  1'b1}, // R4 high end
        '{48'h0000_0300_0000, 1'b0, 1'b0, 1'b0, 4'h0, 4'd0,  1'b0}, // R8 past high
        '{48'h0000_1000_0000, 1'b0, 1'b0, 1'b1, 4'h9, 4'd3,  1'b1}, // R9 ns read
        '{48'h0000_1000_0000, 1'b0, 1'b1, 1'b1, 4'h9, 4'd3,  1'b0}, // R9 secure read
        '{48'h0000_1000_0000, 1'b1, 1'b0, 1'b1, 4'h9, 4'd3,  1'b0}, // R9 ns write ok
        '{48'h0000_1010_0000, 1'b0, 1'b0, 1'b0, 4'h0, 4'd0,  1'b0}, // R8
        '{48'h0000_2000_0000, 1'b0, 1'b0, 1'b0, 4'h0, 4'd0,  1'b0}, // R2 disabled
        '{48'hFFFF_FFF0_0000, 1'b0, 1'b0, 1'b1, 4'hF, 4'd15, 1'b0}, // R4 top block
        '{48'hFFFF_FFEF_FFFF, 1'b0, 1'b0, 1'b0, 4'h0, 4'd0,  1'b0}  // R8
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input int w, input int r, input logic [31:0] d, input logic s);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 9'(w * 32 + r * 4); reg_wdata = d; reg_secure = s;
        @(negedge clk);
        reg_wr = 1'b0; reg_secure = 1'b0;
    endtask

    task automatic rreg(input int w, input int r, input logic s, output logic [31:0] q);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 9'(w * 32 + r * 4); reg_secure = s;
        @(negedge clk);
        reg_rd = 1'b0; reg_secure = 1'b0;
        q = reg_rdata;
    endtask

    // present an address now, sample one edge later
    task automatic dchk(input string tag, input logic [47:0] a, input logic wr, input logic sec,
                        input logic h, input logic [3:0] t, input logic [3:0] i, input logic v);
        dec_addr = a; dec_write = wr; dec_secure = sec;
        @(negedge clk);
        chk(tag, {54'd0, dec_hit, dec_tgt, dec_idx, dec_viol}, {54'd0, h, t, i, v});
    endtask

    task automatic setwin(input int w, input logic [3:0] t, input logic en,
                          input logic [27:0] lo, input logic [27:0] hi, input logic [3:0] s);
        wreg(w, 2, {lo, 4'h0}, 1'b1);
        wreg(w, 3, {hi, 4'h0}, 1'b1);
        wreg(w, 1, {28'd0, s}, 1'b1);
        wreg(w, 0, {20'd0, t, 7'd0, en}, 1'b1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] q;
        repeat (3) @(negedge clk);
        // R13 outputs cleared in reset
        chk("R13 reset outputs", {58'd0, dec_hit, dec_tgt, dec_viol}, 64'd0);
        rst_n = 1'b1;
        // R13 window 0 live after reset, R12 one-cycle decode
        dchk("R13 cfg window after reset", 48'h0, 1'b0, 1'b0, 1'b1, 4'h0, 4'd0, 1'b0);
        rreg(5, 0, 1'b1, q); chk("R13 win5 ctrl zero", 64'(q), 64'h0);
        rreg(5, 2, 1'b1, q); chk("R13 win5 low zero", 64'(q), 64'h0);
        rreg(0, 0, 1'b1, q); chk("R1 R6 win0 ctrl reads enabled", 64'(q), 64'h1);

        // R6 try to disable window 0
        wreg(0, 0, 32'h0000_0500, 1'b1);
        rreg(0, 0, 1'b1, q); chk("R6 win0 enable sticks", 64'(q), 64'h501);
        dchk("R6 win0 still decodes", 48'h0000_0000_1000, 1'b0, 1'b0, 1'b1, 4'h5, 4'd0, 1'b0);
        wreg(0, 0, 32'h0, 1'b1);
        wreg(0, 3, {28'h3FF, 4'h0}, 1'b1); // R5 high of window 0 has no effect

        setwin(1, 4'h3, 1'b1, 28'h10, 28'h1F, 4'h0);
        setwin(2, 4'h5, 1'b1, 28'h18, 28'h2F, 4'h4);
        setwin(3, 4'h9, 1'b1, 28'h100, 28'h100, 4'h8);
        setwin(4, 4'h7, 1'b0, 28'h200, 28'h2FF, 4'h0);
        setwin(15, 4'hF, 1'b1, 28'hFFF_FFFF, 28'hFFF_FFFF, 4'h0);

        // R3 register bits [3:0] read zero
        wreg(4, 2, 32'h0000_2005, 1'b1);
        rreg(4, 2, 1'b0, q); chk("R3 low reg low bits zero", 64'(q), 64'h2000);
        rreg(2, 1, 1'b0, q); chk("R1 security reg readback", 64'(q), 64'h4);

        @(negedge clk);
        for (int k = 0; k < NV; k++) begin
            dchk($sformatf("vector %0d (R2 R4 R5 R7 R8 R9)", k), VEC[k].addr, VEC[k].wr,
                 VEC[k].sec, VEC[k].hit, VEC[k].tgt, VEC[k].idx, VEC[k].viol);
        end

        // R12 write then decode next cycle
        wreg(5, 2, {28'h500, 4'h0}, 1'b1);
        wreg(5, 3, {28'h500, 4'h0}, 1'b1);
        dchk("R12 before enable", 48'h0000_5000_0000, 1'b0, 1'b0, 1'b0, 4'h0, 4'd0, 1'b0);
        wreg(5, 0, 32'h0000_0201, 1'b1);
        dchk("R12 right after enable", 48'h0000_5000_0000, 1'b0, 1'b0, 1'b1, 4'h2, 4'd5, 1'b0);

        // R10 control-write lock
        wreg(3, 1, 32'h9, 1'b1);
        wreg(3, 0, 32'h0, 1'b0);
        dchk("R10 ns ctrl write dropped", 48'h0000_1000_0000, 1'b0, 1'b1, 1'b1, 4'h9, 4'd3, 1'b0);
        wreg(3, 0, 32'h0000_0701, 1'b1);
        dchk("R10 secure ctrl write applied", 48'h0000_1000_0000, 1'b0, 1'b1, 1'b1, 4'h7, 4'd3, 1'b0);

        // R11 control-read lock
        wreg(3, 1, 32'hA, 1'b1);
        rreg(3, 0, 1'b0, q); chk("R11 ns ctrl read zero", 64'(q), 64'h0);
        rreg(3, 0, 1'b1, q); chk("R11 secure ctrl read", 64'(q), 64'h701);

        // R5 relocate window 0
        wreg(0, 2, {28'h400, 4'h0}, 1'b0);
        dchk("R5 relocated start", 48'h0000_4000_0000, 1'b0, 1'b0, 1'b1, 4'h0, 4'd0, 1'b0);
        dchk("R5 relocated last block", 48'h0000_40F0_0000, 1'b0, 1'b0, 1'b1, 4'h0, 4'd0, 1'b0);
        dchk("R5 just past 16 MB", 48'h0000_4100_0000, 1'b0, 1'b0, 1'b0, 4'h0, 4'd0, 1'b0);
        dchk("R5 R8 old base now misses", 48'h0, 1'b0, 1'b0, 1'b0, 4'h0, 4'd0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule